// File: doc/BRIEF.md
# Three-Level Harmonic-Cancelling Waveform Generator

This block turns the phase word of a numerically controlled oscillator into a three-level feedback waveform (+1, 0, -1) for a single-phase grid-synchronising loop. The waveform is notched so that its 3rd, 5th, 7th and 9th harmonics cancel and its fundamental has unit amplitude. When this signal replaces a plain square wave in the loop's multiplier, input harmonics of those orders no longer add a DC term that would bias the phase error.

Only five switching angles for the first quarter period are stored, as constant thresholds on the phase word. The other three quarters come from symmetry. The waveform is even about phase zero, so the fourth quarter mirrors the first in time. The half-wave symmetry makes the second half the negation of the first. The phase word is split into a quarter index, which is the state `Q_PEAK`, `Q_DESCEND`, `Q_TROUGH` or `Q_ASCEND`, and an in-quarter offset. The offset is mirrored in `Q_DESCEND` and `Q_ASCEND`, and the level is negated in `Q_DESCEND` and `Q_TROUGH`. The quarter state follows the top two phase bits. In a phase sweep it steps Q_PEAK→Q_DESCEND→Q_TROUGH→Q_ASCEND→Q_PEAK, but any jump of the phase word can take it straight to any other state.

Top module: `she_wave_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs are cleared to `level_o`=0 and `quarter_o`=0 after that edge.
- R2: Both outputs are registered. A new `phase_i` value shows on the outputs after the next rising clock edge and not before it.
- R3: Quarter 0 (phase 0..16383) uses offset x = phase[13:0]. The level is +1 when x<4657, 0 when 4657≤x<5185, +1 when 5185≤x<8827, 0 when 8827≤x<10717, +1 when 10717≤x<12679, and 0 when x≥12679. Call this first-quarter function g(x). 90° equals 16384 codes.
- R4: `quarter_o` equals phase[15:14] of the phase word that produced the level: 0=Q_PEAK, 1=Q_DESCEND, 2=Q_TROUGH, 3=Q_ASCEND.
- R5: In quarter 1 the level is -g(16383 - phase[13:0]), so it is never positive.
- R6: In quarter 2 the level is -g(phase[13:0]), so it is never positive.
- R7: In quarter 3 the level is +g(16383 - phase[13:0]), so it is never negative.
- R8: `level_o` is two-bit two's complement: 01=+1, 00=0, 11=-1. The code 10 never appears.
- R9: Half-wave symmetry: the level for phase p+32768 (mod 65536) is the negation of the level for phase p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_i | input | 16 | Unsigned oscillator phase, full scale = one period |
| level_o | output | 2 | Signed three-level waveform sample |
| quarter_o | output | 2 | Quarter index of the phase that produced `level_o` |

## Verification
Every wrong internal state has a visible effect one clock after the phase word that exposes it. A bad quarter decode shows up as a wrong `quarter_o` code or as a level with the wrong sign for that quarter. A missing or misplaced mirror moves a notch edge in quarters 1 and 3 by thousands of codes. A wrong or misordered threshold makes the level toggle at the wrong code within the first quarter. For this reason the bench sweeps every phase code once and compares each result with the symmetry rules. It then checks half-wave pairs, the one-cycle latency and the reset state.

// File: rtl/she_wave_pkg.sv
package she_wave_pkg;

    typedef enum logic [1:0] {
        Q_PEAK    = 2'd0,
        Q_DESCEND = 2'd1,
        Q_TROUGH  = 2'd2,
        Q_ASCEND  = 2'd3
    } quarter_e;

    typedef enum logic [1:0] {
        LVL_ZERO = 2'b00,
        LVL_POS  = 2'b01,
        LVL_NEG  = 2'b11
    } level_e;

    localparam int SHE_NUM_ANGLES = 5;

    // switching angles within one quarter, in hundredths of a degree
    function automatic int angle_cdeg(input int idx);
        case (idx)
            0:       return 2558;
            1:       return 2848;
            2:       return 4849;
            3:       return 5887;
            4:       return 6965;
            default: return 9000;
        endcase
    endfunction

    // rounded phase code for an angle, given the codes in one quarter
    function automatic longint angle_code(input int cdeg, input longint quarter_codes);
        return (longint'(cdeg) * quarter_codes * 2 + 64'sd9000) / 64'sd18000;
    endfunction

endpackage

// File: rtl/she_phase_fold.sv
module she_phase_fold
    import she_wave_pkg::*;
#(
    parameter int PHASE_W = 16,
    localparam int OFF_W  = PHASE_W - 2
) (
    input  logic [PHASE_W-1:0] phase_i,
    output quarter_e           quarter_o,
    output logic [OFF_W-1:0]   offset_o,
    output logic               negate_o
);

    logic [OFF_W-1:0] raw_off;

    assign quarter_o = quarter_e'(phase_i[PHASE_W-1 -: 2]);
    assign raw_off   = phase_i[OFF_W-1:0];

    always_comb begin
        unique case (quarter_o)
            Q_PEAK: begin
                offset_o = raw_off;
                negate_o = 1'b0;
            end
            Q_DESCEND: begin
                offset_o = ~raw_off;
                negate_o = 1'b1;
            end
            Q_TROUGH: begin
                offset_o = raw_off;
                negate_o = 1'b1;
            end
            Q_ASCEND: begin
                offset_o = ~raw_off;
                negate_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/she_angle_cmp.sv
module she_angle_cmp
    import she_wave_pkg::*;
#(
    parameter int OFF_W      = 14,
    parameter int NUM_ANGLES = SHE_NUM_ANGLES,
    localparam longint QCODES = longint'(1) << OFF_W
) (
    input  logic [OFF_W-1:0] offset_i,
    output logic             pulse_on_o
);

    logic [NUM_ANGLES-1:0] passed;

    for (genvar i = 0; i < NUM_ANGLES; i++) begin : g_thresh
        localparam logic [OFF_W-1:0] TH = OFF_W'(angle_code(angle_cdeg(i), QCODES));
        assign passed[i] = (offset_i >= TH);
    end

    // level toggles at each crossed angle, starting high at zero offset
    assign pulse_on_o = ~(^passed);

endmodule

// File: rtl/she_level_sel.sv
module she_level_sel
    import she_wave_pkg::*;
(
    input  logic   pulse_on_i,
    input  logic   negate_i,
    output level_e level_o
);

    always_comb begin
        unique case ({pulse_on_i, negate_i})
            2'b10:   level_o = LVL_POS;
            2'b11:   level_o = LVL_NEG;
            default: level_o = LVL_ZERO;
        endcase
    end

endmodule

// File: rtl/she_wave_gen.sv
module she_wave_gen
    import she_wave_pkg::*;
#(
    parameter int PHASE_W    = 16,
    parameter int NUM_ANGLES = SHE_NUM_ANGLES,
    localparam int OFF_W     = PHASE_W - 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase_i,
    output logic [1:0]         level_o,
    output logic [1:0]         quarter_o
);

    quarter_e         quarter_d, quarter_q;
    logic [OFF_W-1:0] folded_off;
    logic             negate;
    logic             pulse_on;
    level_e           level_d, level_q;

    she_phase_fold #(.PHASE_W(PHASE_W)) u_fold (
        .phase_i   (phase_i),
        .quarter_o (quarter_d),
        .offset_o  (folded_off),
        .negate_o  (negate)
    );

    she_angle_cmp #(.OFF_W(OFF_W), .NUM_ANGLES(NUM_ANGLES)) u_cmp (
        .offset_i   (folded_off),
        .pulse_on_o (pulse_on)
    );

    she_level_sel u_sel (
        .pulse_on_i (pulse_on),
        .negate_i   (negate),
        .level_o    (level_d)
    );

    // state register: quarter of the last sampled phase
    always_ff @(posedge clk) begin
        if (rst) quarter_q <= Q_PEAK;
        else     quarter_q <= quarter_d;
    end

    // output register: level
    always_ff @(posedge clk) begin
        if (rst) level_q <= LVL_ZERO;
        else     level_q <= level_d;
    end

    assign level_o   = level_q;
    assign quarter_o = quarter_q;

endmodule

// File: rtl/she_wave_gen_chk.sv
module she_wave_gen_chk #(
    parameter int PHASE_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [PHASE_W-1:0] phase_i,
    input logic [1:0]         level_o,
    input logic [1:0]         quarter_o
);

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (level_o == 2'b00 && quarter_o == 2'b00));

    p_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(phase_i) == $past(phase_i, 2))
        |-> $stable(level_o));

    p_q0_nonneg_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(phase_i[PHASE_W-1 -: 2]) == 2'd0) |-> level_o != 2'b11);

    p_quarter_track_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> quarter_o == $past(phase_i[PHASE_W-1 -: 2]));

    p_q1_nonpos_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(phase_i[PHASE_W-1 -: 2]) == 2'd1) |-> level_o != 2'b01);

    p_q2_nonpos_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(phase_i[PHASE_W-1 -: 2]) == 2'd2) |-> level_o != 2'b01);

    p_q3_nonneg_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(phase_i[PHASE_W-1 -: 2]) == 2'd3) |-> level_o != 2'b11);

    p_legal_code_r8: assert property (@(posedge clk) disable iff (rst)
        level_o != 2'b10);

endmodule

bind she_wave_gen she_wave_gen_chk #(.PHASE_W(PHASE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .phase_i   (phase_i),
    .level_o   (level_o),
    .quarter_o (quarter_o)
);

// File: tb/she_wave_gen_tb.sv
module she_wave_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] phase = 16'd0;
    logic [1:0]  level;
    logic [1:0]  quarter;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    she_wave_gen u_dut (
        .clk       (clk),
        .rst       (rst),
        .phase_i   (phase),
        .level_o   (level),
        .quarter_o (quarter)
    );

    // R3 first-quarter function from the stated thresholds
    function automatic int g_q0(input int x);
        int n;
        n = 0;
        if (x >= 4657)  n++;
        if (x >= 5185)  n++;
        if (x >= 8827)  n++;
        if (x >= 10717) n++;
        if (x >= 12679) n++;
        return (n % 2 == 0) ? 1 : 0;
    endfunction

    function automatic int exp_level(input int p);
        int q, off;
        q   = (p >> 14) & 3;
        off = p & 16383;
        case (q)
            0:       return  g_q0(off);           // R3
            1:       return -g_q0(16383 - off);   // R5
            2:       return -g_q0(off);           // R6
            default: return  g_q0(16383 - off);   // R7
        endcase
    endfunction

    function automatic string req_of(input int p);
        case ((p >> 14) & 3)
            0:       return "R3";
            1:       return "R5";
            2:       return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check_int(input string req, input int act, input int exp, input int p);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s phase=%0d actual=%0d expected=%0d", req, p, act, exp);
        end
    endtask

    task automatic check_point(input int p);
        check_int(req_of(p), int'($signed(level)), exp_level(p), p);
        check_int("R4", int'(quarter), (p >> 14) & 3, p);
        check_int("R8", int'(level == 2'b10), 0, p);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int first_lvl;
        phase = 16'h1234;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_int("R1", int'($signed(level)), 0, 16'h1234);
        check_int("R1", int'(quarter), 0, 16'h1234);
        rst = 1'b0;

        // exhaustive sweep, pipelined: check previous phase, drive next
        for (int p = 0; p < 65536; p++) begin
            @(negedge clk);
            if (p > 0) check_point(p - 1);
            phase = 16'(p);
        end
        @(negedge clk);
        check_point(65535);

        // R2: latency of exactly one edge
        phase = 16'd0;
        @(negedge clk);
        @(negedge clk);
        phase = 16'd32768;
        #1;
        check_int("R2", int'($signed(level)), 1, 32768);
        @(posedge clk);
        #1;
        check_int("R2", int'($signed(level)), -1, 32768);

        // R9: half-wave pairs
        for (int k = 0; k < 256; k++) begin
            int p;
            p = (k * 127 + 11) & 65535;
            @(negedge clk);
            phase = 16'(p);
            @(negedge clk);
            first_lvl = int'($signed(level));
            phase = 16'((p + 32768) & 65535);
            @(negedge clk);
            check_int("R9", int'($signed(level)), -first_lvl, p);
        end

        // R1: reset in mid-run
        phase = 16'd100;
        @(negedge clk);
        rst = 1'b1;
        phase = 16'd49000;
        @(negedge clk);
        check_int("R1", int'($signed(level)), 0, 49000);
        check_int("R1", int'(quarter), 0, 49000);
        rst = 1'b0;
        @(negedge clk);
        check_point(49000);

        done = 1'b1;
        finish_run();
    end

endmodule